// File: doc/BRIEF.md
# Double-Buffered Parallel-Serial Shift Channel

This block is one serial lane of a scan-test master. It holds two byte registers that act as a two-entry FIFO. While the host accesses one register in parallel, the other register moves one bit for each cycle in which the shift strobe is high. A direction parameter chooses between two variants. The outgoing variant takes parallel bytes from the host and drives a serial line. The incoming variant samples a serial line and hands whole bytes back to the host.

Local control decides which register is loaded and which is shifted, and swaps them after each byte. It reports full and empty flags. It also drives a `ready` output that the test-clock gating logic outside the block uses: scanning proceeds only while the lane has data to send or space to receive. A mode input takes the lane out of ongoing scan operations without losing its state.

Top module: `dbsh_channel`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), both registers are free: `empty`=1, `full`=0, `ser_out`=0, `host_rdata`=0, and the outgoing variant holds `ready`=0.
- R2: `full` is 1 exactly when both registers hold a byte. `empty` is 1 exactly when neither does.
- R3: Outgoing variant (DIR_OUT): bytes leave in the order they were written, least-significant bit first. `ser_out` shows the current bit and advances on each clock edge where `shift_en`=1 and `ready`=1. `ser_out` is 0 while no byte is loaded.
- R4: Outgoing variant: when a byte's eighth bit shifts and the other register is loaded, bit 0 of that byte appears on `ser_out` in the very next cycle, with no idle cycle between bytes.
- R5: Outgoing variant: `ready` = `chan_en` AND (at least one loaded byte remains).
- R6: Outgoing variant: a `host_wr` while `full`=1 is ignored, and neither the flags nor the queued data change.
- R7: Incoming variant (DIR_IN): each shift samples `ser_in` into the next bit position, least-significant bit first. After eight shifts, the byte is queued, and `host_rdata` shows the oldest queued byte until a `host_rd` pops it.
- R8: Incoming variant: `ready` = `chan_en` AND NOT `full`. `shift_en` while `full` has no effect on the queued bytes.
- R9: Incoming variant: a `host_rd` while `empty`=1 is ignored, and `host_rdata` is 0 while empty.
- R10: While `chan_en`=0, `shift_en` has no effect, and a partly shifted byte resumes where it stopped once `chan_en` returns to 1.
- R11: The host operation that belongs to the other variant is ignored: `host_rd` on an outgoing lane and `host_wr` on an incoming lane leave the flags and data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Mode bit; 1 lets the lane take part in scanning |
| shift_en | input | 1 | Shift strobe, one bit per high cycle |
| host_wr | input | 1 | Host byte write (outgoing variant) |
| host_wdata | input | WIDTH | Byte written by the host |
| host_rd | input | 1 | Host byte read/pop (incoming variant) |
| host_rdata | output | WIDTH | Oldest received byte, 0 when empty |
| ser_in | input | 1 | Serial input line (incoming variant) |
| ser_out | output | 1 | Serial output line (outgoing variant) |
| ready | output | 1 | Lane can shift now; feeds test-clock gating |
| full | output | 1 | Both registers occupied |
| empty | output | 1 | No register occupied |

## Verification
Every one of the 256 byte values is written into an outgoing lane and looped serially into an incoming lane, then read back. A bit-order or bit-count fault therefore shows up as a wrong value for some byte. Two bytes are shifted as one sixteen-strobe burst, and a second byte is written while the first is partly shifted. These two patterns separate correct ping-pong hand-off from a lost or doubled cycle. Strobes are also applied with the mode bit low, while the lane is full, and as wrong-side host operations; each is followed by a readout of the data that would have been disturbed.

// File: rtl/dbsh_pkg.sv
package dbsh_pkg;

   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } chan_dir_e;

   localparam int unsigned SLOT_COUNT = 2;

endpackage

// File: rtl/dbsh_stage.sv
module dbsh_stage #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             ser_bit,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 2) begin : g_width_bad
      $error("dbsh_stage: WIDTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= ld_data;
      end else if (shift) begin
         q <= {ser_bit, q[WIDTH-1:1]};
      end
   end

   // load and shift come from separate slot selects in the top
   assert_ctl_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/dbsh_bitcount.sv
module dbsh_bitcount #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [CW-1:0] cnt,
   output logic          done
);

   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   assign done = step && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (step) begin
         cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
      end
   end

   assert_count_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));

   assert_count_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (cnt == '0));

endmodule

// File: rtl/dbsh_occupancy.sv
module dbsh_occupancy (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fill_req,
   input  logic       drain_req,
   output logic [1:0] occ,
   output logic       fill_ptr,
   output logic       drain_ptr,
   output logic       full,
   output logic       empty
);

   logic fill_ok;
   logic drain_ok;

   assign full     = &occ;
   assign empty    = ~|occ;
   assign fill_ok  = fill_req && !full;
   assign drain_ok = drain_req && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ       <= '0;
         fill_ptr  <= 1'b0;
         drain_ptr <= 1'b0;
      end else begin
         if (fill_ok) begin
            occ[fill_ptr] <= 1'b1;
            fill_ptr      <= ~fill_ptr;
         end
         if (drain_ok) begin
            occ[drain_ptr] <= 1'b0;
            drain_ptr      <= ~drain_ptr;
         end
      end
   end

   assert_fill_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && full && !drain_req) |=> (occ == $past(occ)));

   assert_drain_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_req && empty && !fill_req) |=> (occ == $past(occ)));

   assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !full && !drain_req) |=>
         ($countones(occ) == $past($countones(occ)) + 1));

endmodule

// File: rtl/dbsh_channel.sv
module dbsh_channel
   import dbsh_pkg::*;
#(
   parameter int unsigned WIDTH = 8,
   parameter chan_dir_e   DIR   = DIR_OUT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             shift_en,
   input  logic             host_wr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic             host_rd,
   output logic [WIDTH-1:0] host_rdata,
   input  logic             ser_in,
   output logic             ser_out,
   output logic             ready,
   output logic             full,
   output logic             empty
);

   localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   if (WIDTH < 2) begin : g_width_bad
      $error("dbsh_channel: WIDTH must be at least 2");
   end

   logic [1:0]       occ;
   logic             fill_ptr;
   logic             drain_ptr;
   logic             fill_req;
   logic             drain_req;
   logic             step;
   logic             done;
   logic [CW-1:0]    cnt;
   logic             ser_bit;
   logic [WIDTH-1:0] ld_data;
   logic [1:0]       st_load;
   logic [1:0]       st_shift;
   logic [WIDTH-1:0] stage_q [SLOT_COUNT];

   dbsh_occupancy u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_req  (fill_req),
      .drain_req (drain_req),
      .occ       (occ),
      .fill_ptr  (fill_ptr),
      .drain_ptr (drain_ptr),
      .full      (full),
      .empty     (empty)
   );

   dbsh_bitcount #(.WIDTH(WIDTH)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .cnt   (cnt),
      .done  (done)
   );

   for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_stage
      dbsh_stage #(.WIDTH(WIDTH)) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (st_load[g]),
         .shift   (st_shift[g]),
         .ld_data (ld_data),
         .ser_bit (ser_bit),
         .q       (stage_q[g])
      );
   end

   if (DIR == DIR_OUT) begin : g_out
      logic unused_out;
      assign unused_out = ^{host_rd, ser_in};

      assign step       = chan_en && shift_en && !empty;
      assign fill_req   = host_wr;
      assign drain_req  = done;
      assign ready      = chan_en && !empty;
      assign ser_bit    = 1'b0;
      assign ld_data    = host_wdata;
      assign ser_out    = empty ? 1'b0 : stage_q[drain_ptr][0];
      assign host_rdata = '0;

      for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_ctl
         assign st_load[s]  = host_wr && !full && (fill_ptr == 1'(s));
         assign st_shift[s] = step && (drain_ptr == 1'(s));
      end

      assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (done && full) |=> (!empty && drain_ptr != $past(drain_ptr)));

      assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en |=> $stable(cnt));
   end else begin : g_in
      logic unused_in;
      assign unused_in = ^{host_wr, host_wdata};

      assign step       = chan_en && shift_en && !full;
      assign fill_req   = done;
      assign drain_req  = host_rd;
      assign ready      = chan_en && !full;
      assign ser_bit    = ser_in;
      assign ld_data    = '0;
      assign ser_out    = 1'b0;
      assign host_rdata = empty ? '0 : stage_q[drain_ptr];

      for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_ctl
         assign st_load[s]  = 1'b0;
         assign st_shift[s] = step && (fill_ptr == 1'(s));
      end

      assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (full && !host_rd) |=> (full && $stable(cnt)));

      assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !chan_en |=> $stable(cnt));
   end

endmodule

// File: tb/sim_dbsh_channel.sv
`timescale 1ns/100ps
module sim_dbsh_channel;
   import dbsh_pkg::*;

   localparam int unsigned W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         o_en = 1'b0, o_sh = 1'b0, o_wr = 1'b0, o_rd = 1'b0;
   logic [W-1:0] o_wdata = '0;
   logic [W-1:0] o_rdata;
   logic         o_ser_out, o_ready, o_full, o_empty;

   logic         i_en = 1'b0, i_sh = 1'b0, i_wr = 1'b0, i_rd = 1'b0;
   logic         i_ser = 1'b0, loop = 1'b0;
   logic [W-1:0] i_rdata;
   logic         i_ser_out, i_ready, i_full, i_empty, i_line;

   assign i_line = loop ? o_ser_out : i_ser;

   int checks = 0;
   int errors = 0;

   dbsh_channel #(.WIDTH(W), .DIR(DIR_OUT)) u0 (
      .clk(clk), .rst_n(rst_n), .chan_en(o_en), .shift_en(o_sh),
      .host_wr(o_wr), .host_wdata(o_wdata), .host_rd(o_rd), .host_rdata(o_rdata),
      .ser_in(1'b0), .ser_out(o_ser_out), .ready(o_ready), .full(o_full), .empty(o_empty));

   dbsh_channel #(.WIDTH(W), .DIR(DIR_IN)) u1 (
      .clk(clk), .rst_n(rst_n), .chan_en(i_en), .shift_en(i_sh),
      .host_wr(i_wr), .host_wdata(8'hFF), .host_rd(i_rd), .host_rdata(i_rdata),
      .ser_in(i_line), .ser_out(i_ser_out), .ready(i_ready), .full(i_full), .empty(i_empty));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic o_write(input logic [W-1:0] v);
      @(negedge clk); o_wr = 1'b1; o_wdata = v;
      @(negedge clk); o_wr = 1'b0;
   endtask

   // collect n presented bits, strobing shift each cycle
   task automatic o_collect(input int n, output logic [31:0] bits, output int rdy);
      bits = '0; rdy = 0;
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         bits[k] = o_ser_out;
         rdy += int'(o_ready);
         o_sh = 1'b1;
         @(negedge clk);
      end
      o_sh = 1'b0;
   endtask

   task automatic i_shift(input logic [W-1:0] v);
      @(negedge clk);
      for (int k = 0; k < W; k++) begin
         i_sh = 1'b1; i_ser = v[k];
         @(negedge clk);
      end
      i_sh = 1'b0;
   endtask

   task automatic i_read(output logic [W-1:0] v);
      @(negedge clk); i_rd = 1'b1; v = i_rdata;
      @(negedge clk); i_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] bits, b2;
      int rdy;
      logic [W-1:0] rv;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 out empty", o_empty, 1);
      chk("R1 out full", o_full, 0);
      chk("R1 out ready", o_ready, 0);
      chk("R1 ser_out", o_ser_out, 0);
      chk("R1 in empty", i_empty, 1);
      chk("R1 in rdata", i_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 / R5: loaded but disabled
      o_write(8'hA5);
      chk("R2 one byte not empty", o_empty, 0);
      chk("R5 ready low when disabled", o_ready, 0);
      o_collect(5, bits, rdy);
      chk("R10 strobes ignored while disabled", bits[4:0], 5'b11111);
      o_en = 1'b1;
      o_collect(8, bits, rdy);
      chk("R3 byte out lsb first", bits[7:0], 8'hA5);
      chk("R5 ready while loaded", rdy, 8);
      chk("R2 empty after drain", o_empty, 1);
      chk("R5 ready low when empty", o_ready, 0);
      chk("R3 ser_out idle", o_ser_out, 0);

      // R10 partial hold
      o_write(8'h3C);
      o_collect(3, bits, rdy);
      o_en = 1'b0;
      o_collect(4, b2, rdy);
      chk("R10 held bit while disabled", b2[3:0], {4{1'b1}});
      o_en = 1'b1;
      o_collect(5, b2, rdy);
      chk("R10 resume partial byte", {b2[4:0], bits[2:0]}, 8'h3C);

      // R2 / R6 / R4 full, overflow, back-to-back
      o_write(8'h11);
      o_write(8'h22);
      chk("R2 full", o_full, 1);
      o_write(8'h33);
      chk("R6 full after ignored write", o_full, 1);
      o_collect(16, bits, rdy);
      chk("R4 two bytes no gap", bits[15:0], 16'h2211);
      chk("R5 ready through burst", rdy, 16);
      chk("R6 extra byte dropped", o_empty, 1);

      // R4 refill during shift
      o_write(8'h5A);
      o_collect(4, bits, rdy);
      o_write(8'hC3);
      o_collect(12, b2, rdy);
      chk("R4 refill while shifting", {b2[11:0], bits[3:0]}, 16'hC35A);

      // R11 outgoing read ignored
      o_write(8'h96);
      @(negedge clk); o_rd = 1'b1;
      @(negedge clk); o_rd = 1'b0;
      chk("R11 out read keeps byte", o_empty, 0);
      o_collect(8, bits, rdy);
      chk("R11 out byte intact", bits[7:0], 8'h96);

      // incoming
      i_en = 1'b1;
      i_read(rv);
      chk("R9 read empty data", rv, 0);
      chk("R9 still empty", i_empty, 1);
      @(negedge clk); i_wr = 1'b1;
      @(negedge clk); i_wr = 1'b0;
      chk("R11 in write ignored", i_empty, 1);
      i_en = 1'b0;
      i_shift(8'hEE);
      chk("R10 in disabled no capture", i_empty, 1);
      chk("R8 in ready low when disabled", i_ready, 0);
      i_en = 1'b1;
      i_shift(8'h81);
      chk("R7 first byte", i_rdata, 8'h81);
      i_shift(8'h7E);
      chk("R2 in full", i_full, 1);
      chk("R8 ready low when full", i_ready, 0);
      i_shift(8'hFF);
      chk("R8 full strobes ignored", i_rdata, 8'h81);
      i_read(rv);
      chk("R7 pop oldest", rv, 8'h81);
      chk("R7 next byte", i_rdata, 8'h7E);
      i_read(rv);
      chk("R7 second pop", rv, 8'h7E);
      chk("R2 in empty again", i_empty, 1);

      // exhaustive loopback R3 R7
      loop = 1'b1;
      for (int v = 0; v < 256; v++) begin
         o_write(8'(v));
         @(negedge clk);
         for (int k = 0; k < W; k++) begin
            o_sh = 1'b1; i_sh = 1'b1;
            @(negedge clk);
         end
         o_sh = 1'b0; i_sh = 1'b0;
         i_read(rv);
         chk("R3 R7 loopback value", rv, 32'(v));
      end
      chk("R2 both empty at end", {o_empty, i_empty}, 2'b11);

      finish_run();
   end

endmodule